// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Registers

This block holds the machine-level interrupt enable, interrupt delegation, exception delegation and interrupt pending state of a hart. It also provides the supervisor-level views of enable and pending. Each view is a window that shows, and lets software change, only the bits that the interrupt delegation register hands to supervisor level.

Software reaches every register through one read-modify-write port. An access carries a register selector, write data and a per-bit write mask, and returns the register's value from before the access. Plain read, write, set and clear operations differ only in the data and mask the requester drives.

Pending bits combine two sources. Six hardware lines drive the machine and supervisor software, timer and external interrupts. A software-written latch exists only for the supervisor interrupt bits. A hardware-claim mask takes any bit away from software control.

Top module: `irq_deleg_regs`

## Requirements
- R1: After reset, the enable, interrupt delegation, exception delegation and software pending state are all zero.
- R2: An access with `csr_en` high forms `(old & ~csr_wmask) | (csr_wdata & csr_wmask)` and commits it on the next rising edge. The selector codes are: 0 = enable, 1 = interrupt delegation, 2 = exception delegation, 3 = machine pending, 4 = supervisor enable, 5 = supervisor pending. For the enable register, only bits 1, 3, 5, 7, 9 and 11 take the new value.
- R3: For the interrupt delegation register, only bits 1, 5 and 9 take the new value. All other bits keep their previous value, which is zero.
- R4: For the exception delegation register, only bits 0 to 13 and bit 15 take the new value. Bit 14 never changes.
- R5: `csr_rdata` returns, in the same cycle as the access, the selected register's value before the write. Selector codes 6 and 7 read zero and change nothing. With `csr_en` low, no register changes.
- R6: A supervisor-enable read returns the enable register ANDed with the interrupt delegation register.
- R7: A supervisor-enable write changes only enable bits that are set in the interrupt delegation register.
- R8: Pending bit 2i+1 carries `hw_irq[i]`: i=0 supervisor software, 1 machine software, 2 supervisor timer, 3 machine timer, 4 supervisor external, 5 machine external. Machine bits 3, 7 and 11 follow the hardware lines only.
- R9: A machine-pending write sets or clears the software latch under the mask `csr_wmask & (bits 1,5,9) & ~hw_claim`. A claimed bit shows only its hardware line. An unclaimed supervisor bit shows the hardware line ORed with the latch.
- R10: A supervisor-pending write is further limited by the mask of bits 0, 1 and 8, and by the interrupt delegation register. In effect only bit 1 can be written, and only while it is delegated.
- R11: A supervisor-pending access returns the old pending value ANDed with interrupt delegation. A machine-pending access returns the full old pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access strobe |
| csr_sel | input | 3 | Register selector |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Per-bit write mask |
| csr_rdata | output | XLEN | Old value of the selected register |
| hw_irq | input | 6 | Hardware pending lines |
| hw_claim | input | XLEN | Pending bits owned by hardware |
| ie_o | output | XLEN | Current enable vector |
| ip_o | output | XLEN | Current pending vector |
| ideleg_o | output | XLEN | Current interrupt delegation vector |
| edeleg_o | output | XLEN | Current exception delegation vector |

## Verification
Two things can land on the same pending bit in the same cycle: a software write through either pending view, and a change of the hardware line or claim mask. The bench provokes this by randomising `hw_irq` and `hw_claim` together with pending writes, alongside directed cases. These include setting a claimed bit, clearing a bit whose hardware line is high, and writing the supervisor view while delegation is off. Each cycle, the returned old value and the next pending vector are compared with a bench model built from the OR and claim rules.

// File: rtl/irq_deleg_regs.sv
module irq_deleg_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] csr_wmask,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [5:0]      hw_irq,
  input  logic [XLEN-1:0] hw_claim,
  output logic [XLEN-1:0] ie_o,
  output logic [XLEN-1:0] ip_o,
  output logic [XLEN-1:0] ideleg_o,
  output logic [XLEN-1:0] edeleg_o
);
  localparam logic [XLEN-1:0] IE_OK   = XLEN'(16'h0AAA);
  localparam logic [XLEN-1:0] SUP_INT = XLEN'(16'h0222);
  localparam logic [XLEN-1:0] EXC_OK  = XLEN'(16'hBFFF);
  localparam logic [XLEN-1:0] SIP_WR  = XLEN'(16'h0103);
  localparam logic [2:0] S_IE = 3'd0, S_ID = 3'd1, S_ED = 3'd2,
                         S_IP = 3'd3, S_SIE = 3'd4, S_SIP = 3'd5;

  logic [XLEN-1:0] ie_q, id_q, ed_q, sw_q;
  logic [XLEN-1:0] hw_vec, ip, old, nv, sie_mix, sw_m;
  logic [XLEN-1:0] ie_d, id_d, ed_d, sw_d;

  always_comb begin
    hw_vec = '0;
    for (int i = 0; i < 6; i++) hw_vec[2*i+1] = hw_irq[i];
  end

  assign ip = hw_vec | (sw_q & ~hw_claim);

  always_comb begin
    case (csr_sel)
      S_IE:    old = ie_q;
      S_ID:    old = id_q;
      S_ED:    old = ed_q;
      S_IP:    old = ip;
      S_SIE:   old = ie_q & id_q;
      S_SIP:   old = ip & id_q;
      default: old = '0;
    endcase
  end

  assign nv      = (old & ~csr_wmask) | (csr_wdata & csr_wmask);
  assign sie_mix = (ie_q & ~id_q) | (nv & id_q);

  always_comb begin
    ie_d = ie_q;
    id_d = id_q;
    ed_d = ed_q;
    sw_m = '0;
    case (csr_sel)
      S_IE:  ie_d = (ie_q & ~IE_OK) | (nv & IE_OK);
      S_SIE: ie_d = (ie_q & ~IE_OK) | (sie_mix & IE_OK);
      S_ID:  id_d = (id_q & ~SUP_INT) | (nv & SUP_INT);
      S_ED:  ed_d = (ed_q & ~EXC_OK) | (nv & EXC_OK);
      S_IP:  sw_m = csr_wmask & SUP_INT & ~hw_claim;
      S_SIP: sw_m = csr_wmask & id_q & SIP_WR & SUP_INT & ~hw_claim;
      default: ;
    endcase
  end

  assign sw_d = (sw_q & ~sw_m) | (csr_wdata & sw_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      id_q <= '0;
      ed_q <= '0;
      sw_q <= '0;
    end else if (csr_en) begin
      ie_q <= ie_d;
      id_q <= id_d;
      ed_q <= ed_d;
      sw_q <= sw_d;
    end
  end

  assign csr_rdata = old;
  assign ie_o      = ie_q;
  assign ip_o      = ip;
  assign ideleg_o  = id_q;
  assign edeleg_o  = ed_q;
endmodule

module irq_deleg_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_en,
  input logic [2:0]      csr_sel,
  input logic [XLEN-1:0] csr_rdata,
  input logic [5:0]      hw_irq,
  input logic [XLEN-1:0] hw_claim,
  input logic [XLEN-1:0] ie_o,
  input logic [XLEN-1:0] ip_o,
  input logic [XLEN-1:0] ideleg_o,
  input logic [XLEN-1:0] edeleg_o
);
  // R2
  ie_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_o & ~XLEN'(16'h0AAA)) == '0);
  // R3
  ideleg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ideleg_o & ~XLEN'(16'h0222)) == '0);
  // R4
  edeleg_b14_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edeleg_o[14] == 1'b0);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |=> $stable(ie_o) && $stable(ideleg_o) && $stable(edeleg_o));
  // R6
  sie_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_sel == 3'd4) |-> csr_rdata == (ie_o & ideleg_o));
  // R7
  sie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_sel == 3'd4) |=> ((ie_o ^ $past(ie_o)) & ~$past(ideleg_o)) == '0);
  // R8
  mpend_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ip_o[3] == hw_irq[1] && ip_o[7] == hw_irq[3] && ip_o[11] == hw_irq[5]);
  // R9
  claim_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_claim[1] || ip_o[1] == hw_irq[0]) && (!hw_claim[5] || ip_o[5] == hw_irq[2])
    && (!hw_claim[9] || ip_o[9] == hw_irq[4]));
  // R11
  sip_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_sel == 3'd5) |-> csr_rdata == (ip_o & ideleg_o));
endmodule

bind irq_deleg_regs irq_deleg_chk #(.XLEN(XLEN)) i_irq_deleg_chk (
  .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_sel(csr_sel),
  .csr_rdata(csr_rdata), .hw_irq(hw_irq), .hw_claim(hw_claim),
  .ie_o(ie_o), .ip_o(ip_o), .ideleg_o(ideleg_o), .edeleg_o(edeleg_o)
);

// File: tb/test_irq_deleg_regs.sv
module test_irq_deleg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0, csr_en = 1'b0;
  logic [2:0] csr_sel = '0;
  logic [XLEN-1:0] csr_wdata = '0, csr_wmask = '0, hw_claim = '0;
  logic [5:0] hw_irq = '0;
  logic [XLEN-1:0] csr_rdata, ie_o, ip_o, ideleg_o, edeleg_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [XLEN-1:0] m_ie = '0, m_id = '0, m_ed = '0, m_sw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_deleg_regs #(.XLEN(XLEN)) i_irq_deleg_regs (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_wmask(csr_wmask), .csr_rdata(csr_rdata),
    .hw_irq(hw_irq), .hw_claim(hw_claim), .ie_o(ie_o), .ip_o(ip_o),
    .ideleg_o(ideleg_o), .edeleg_o(edeleg_o));

  function automatic logic [XLEN-1:0] exp_ip();
    logic [XLEN-1:0] h = '0;
    for (int i = 0; i < 6; i++) h[2*i+1] = hw_irq[i];
    return h | (m_sw & ~hw_claim);
  endfunction

  function automatic logic [XLEN-1:0] exp_old(input logic [2:0] s);
    case (s)
      3'd0: return m_ie;
      3'd1: return m_id;
      3'd2: return m_ed;
      3'd3: return exp_ip();
      3'd4: return m_ie & m_id;
      3'd5: return exp_ip() & m_id;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R9";
      3'd4: return "R7";
      3'd5: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_commit(input logic [2:0] s, input logic [XLEN-1:0] wd,
                              input logic [XLEN-1:0] wm);
    logic [XLEN-1:0] o, nv, t, m;
    o  = exp_old(s);
    nv = (o & ~wm) | (wd & wm);
    m  = '0;
    case (s)
      3'd0: m_ie = (m_ie & ~32'h0AAA) | (nv & 32'h0AAA);
      3'd1: m_id = (m_id & ~32'h0222) | (nv & 32'h0222);
      3'd2: m_ed = (m_ed & ~32'hBFFF) | (nv & 32'hBFFF);
      3'd3: m = wm & 32'h0222 & ~hw_claim;
      3'd4: begin
        t = (m_ie & ~m_id) | (nv & m_id);
        m_ie = (m_ie & ~32'h0AAA) | (t & 32'h0AAA);
      end
      3'd5: m = wm & m_id & 32'h0002 & ~hw_claim;
      default: ;
    endcase
    m_sw = (m_sw & ~m) | (wd & m);
  endtask

  task automatic op(input logic en, input logic [2:0] s, input logic [XLEN-1:0] wd,
                    input logic [XLEN-1:0] wm, input logic [5:0] hw,
                    input logic [XLEN-1:0] cl);
    @(negedge clk);
    csr_en = en; csr_sel = s; csr_wdata = wd; csr_wmask = wm;
    hw_irq = hw; hw_claim = cl;
    #1;
    if (en) begin
      check(s == 3'd5 ? "R11" : (s == 3'd4 ? "R6" : "R5"), "rdata", csr_rdata, exp_old(s));
      model_commit(s, wd, wm);
    end
    @(posedge clk);
    #1;
    check(en ? req_of(s) : "R5", "ie", ie_o, m_ie);
    check(en ? req_of(s) : "R5", "ideleg", ideleg_o, m_id);
    check(en ? req_of(s) : "R5", "edeleg", edeleg_o, m_ed);
    check("R8", "ip", ip_o, exp_ip());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [XLEN-1:0] wm;
    seed = $urandom(32'h1d5);
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1", "ie", ie_o, '0);
    check("R1", "ideleg", ideleg_o, '0);
    check("R1", "edeleg", edeleg_o, '0);
    check("R1", "ip", ip_o, '0);
    rst_n = 1'b1;
    // R2 R3 R4 legal bits with full writes
    op(1, 3'd0, '1, '1, 6'h0, '0);
    check("R2", "ie all", ie_o, 32'h0AAA);
    op(1, 3'd1, '1, '1, 6'h0, '0);
    check("R3", "ideleg all", ideleg_o, 32'h0222);
    op(1, 3'd2, '1, '1, 6'h0, '0);
    check("R4", "edeleg all", edeleg_o, 32'hBFFF);
    // R5 unused selector and idle cycle
    op(1, 3'd7, '1, '1, 6'h0, '0);
    op(0, 3'd0, '0, '1, 6'h0, '0);
    // R7 supervisor enable clear with only bit 5 delegated
    op(1, 3'd1, 32'h0020, 32'h0222, 6'h0, '0);
    op(1, 3'd4, 32'h0, '1, 6'h0, '0);
    check("R7", "ie sie clear", ie_o, 32'h0A8A);
    // R10 supervisor pending write while bit 1 not delegated
    op(1, 3'd5, '1, '1, 6'h0, '0);
    check("R10", "ip undelegated", ip_o, 32'h0);
    // R9 machine pending write, bit 5 claimed, hw stip high
    op(1, 3'd3, '1, '1, 6'h04, 32'h0020);
    check("R9", "ip claimed", ip_o, 32'h0222);
    // R9 clear with hw line high keeps hw value
    op(1, 3'd3, '0, '1, 6'h3F, '0);
    check("R9", "ip hw held", ip_o, 32'h0AAA);
    // R8 machine bits only from hardware
    op(1, 3'd3, '1, 32'h0888, 6'h0, '0);
    check("R8", "ip machine", ip_o, 32'h0);
    // R10 supervisor pending write with delegation
    op(1, 3'd1, '1, '1, 6'h0, '0);
    op(1, 3'd5, '1, '1, 6'h0, '0);
    check("R10", "ip sip set", ip_o, 32'h0002);
    for (int n = 0; n < 3000; n++) begin
      case ($urandom % 3)
        0: wm = '1;
        1: wm = '0;
        default: wm = $urandom;
      endcase
      op(($urandom % 8) != 0, 3'($urandom), $urandom, wm, 6'($urandom),
         $urandom & 32'h0222);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule